// File: doc/BRIEF.md
# Receive Checksum Offload Engine

This block sits on the receive byte stream of an Ethernet MAC. It forms a 16-bit ones'-complement checksum over the part of each frame that carries the network-layer packet, so that software only has to finish the protocol check. Bytes arrive one per cycle when `in_valid` is high. `in_last` marks the final byte of the frame, and that byte is the last byte of the 4-byte frame check sequence. The checksum comes out with a one-cycle strobe just after the frame ends.

A mode input selects where summing starts. In header-skip mode, summing starts after the fixed 14-byte MAC header. In layer-3 mode, the block parses the frame first. It steps over up to two stacked VLAN tags, each recognised by a programmable tag type, and over an LLC/SNAP header, so that summing starts on the first network-layer byte. In both modes the frame check sequence is held back in a short delay line and never enters the sum.

Top module: `rx_csum_engine`

## Requirements
- R1: While reset is asserted, and until the first frame ends, `csum_valid` is 0 and `csum_out` is 0.
- R2: `csum_valid` is high for exactly the one cycle after each cycle with `in_valid` and `in_last` both high. In that cycle `csum_out` holds the result for the frame. `csum_out` keeps that value until the next frame ends.
- R3: The last 4 bytes of a frame are never added to the sum. A frame of 18 bytes or fewer in header-skip mode gives a result of 0x0000.
- R4: With `cfg_l3_mode`=0, summing starts at byte offset 14, whatever the value of bytes 12–13.
- R5: With `cfg_l3_mode`=1, if the big-endian field at bytes 12–13 is at least 0x0600 and differs from `cfg_tag_type`, summing starts at offset 14.
- R6: With `cfg_l3_mode`=1, a field equal to `cfg_tag_type` marks a 4-byte tag: two type bytes, then two tag-body bytes. The type/length field is read again right after the tag, so one tag moves the start to offset 18.
- R7: At most two tags are skipped. Two tags move the start to 22. A third field that equals `cfg_tag_type` is treated as an ordinary type field, so summing again starts at 22.
- R8: The tag type is not fixed. With `cfg_tag_type`=0x88A8, a field of 0x88A8 is skipped as a tag, and 0x8100 is treated as an ordinary type.
- R9: With `cfg_l3_mode`=1, a type/length field below 0x0600 that is followed by the bytes AA AA 03 introduces an 8-byte LLC/SNAP header (3 LLC bytes, 3 OUI bytes, 2 type bytes). That header is skipped, including when it follows a tag.
- R10: With `cfg_l3_mode`=1, a field below 0x0600 that is not followed by AA AA 03 is a plain length field. Summing starts right after it.
- R11: The sum adds big-endian 16-bit words, the first summed byte being the high byte, with end-around carry. An odd final byte is padded with a zero low byte. The result is not complemented.
- R12: Cycles with `in_valid` low have no effect. Frames may follow one another with no idle cycle, and each result depends only on its own frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_l3_mode | input | 1 | 0: start after the 14-byte header; 1: parse tags and LLC/SNAP. Held stable during a frame |
| cfg_tag_type | input | 16 | Type value that marks a VLAN tag (commonly 0x8100) |
| in_valid | input | 1 | A frame byte is present on `in_data` |
| in_data | input | 8 | Frame byte, in wire order |
| in_last | input | 1 | Final byte of the frame (end of the check sequence) |
| csum_valid | output | 1 | One-cycle strobe: `csum_out` carries a new result |
| csum_out | output | 16 | Ones'-complement sum of the selected span |

## Verification
Most internal faults show up only as a wrong `csum_out`, and only in the strobe cycle after the frame's last byte. A parser stuck in the wrong state, or one that miscounts a skip, moves the start offset. A word then changes position or drops out of the sum, so each parse path needs its own frame with a known expected sum. A delay line that pops too early or too late lets check-sequence bytes in, or drops payload. A wrong byte-pairing bit swaps the high and low halves of every later word. A fault in frame-end cleanup shows up only in the next frame's result, so frames are sent back to back.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;

  // Type/length values below this are frame lengths, not protocol types
  localparam logic [WORD_W-1:0] LEN_CEIL = 16'h0600;

  // LLC bytes that announce a SNAP header
  localparam logic [BYTE_W-1:0] SNAP_SAP = 8'hAA;
  localparam logic [BYTE_W-1:0] SNAP_UI  = 8'h03;

  typedef enum logic [2:0] {
    PS_HDR,   // skipping address bytes or a tag body
    PS_THI,   // high byte of a type/length field
    PS_TLO,   // low byte of a type/length field: decision point
    PS_SNAP,  // skipping the LLC/SNAP header
    PS_SUM    // every byte belongs to the summed span
  } parse_st_e;

endpackage

// File: rtl/rxc_fcs_delay.sv
module rxc_fcs_delay #(
  parameter int unsigned DEPTH = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid_i,
  input  logic [rxc_pkg::BYTE_W-1:0]      in_data_i,
  input  logic                            in_last_i,
  output logic                            pop_valid_o,
  output logic [rxc_pkg::BYTE_W-1:0]      pop_byte_o,
  output logic [DEPTH-2:0][rxc_pkg::BYTE_W-1:0] ahead_o,
  output logic [$clog2(DEPTH+1)-1:0]      fill_o
);
  import rxc_pkg::*;

  localparam int unsigned FW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][BYTE_W-1:0] stg_q, stg_d, shf;
  logic [FW-1:0]                fill_q, fill_d;
  logic                         full;

  assign full = (fill_q == FW'(DEPTH));
  assign shf  = {in_data_i, stg_q[DEPTH-1:1]};

  // Each stage either shifts toward the head or captures the first free slot
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
    assign stg_d[gi] = !in_valid_i            ? stg_q[gi] :
                       full                   ? shf[gi]   :
                       (fill_q == FW'(gi))    ? in_data_i : stg_q[gi];
  end

  always_comb begin
    fill_d = fill_q;
    if (in_valid_i && in_last_i) begin
      fill_d = '0;
    end else if (in_valid_i && !full) begin
      fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      fill_q <= '0;
    end else begin
      stg_q  <= stg_d;
      fill_q <= fill_d;
    end
  end

  assign pop_valid_o = in_valid_i && full;
  assign pop_byte_o  = stg_q[0];
  assign ahead_o     = stg_q[DEPTH-1:1];
  assign fill_o      = fill_q;

endmodule

// File: rtl/rxc_hdr_parser.sv
module rxc_hdr_parser #(
  parameter int unsigned MAC_ADDR_BYTES = 12,
  parameter int unsigned TAG_BODY_BYTES = 2,
  parameter int unsigned SNAP_BYTES     = 8,
  parameter int unsigned MAX_TAGS       = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        l3_mode_i,
  input  logic [rxc_pkg::WORD_W-1:0]  tag_type_i,
  input  logic                        pop_valid_i,
  input  logic [rxc_pkg::BYTE_W-1:0]  pop_byte_i,
  input  logic [rxc_pkg::BYTE_W-1:0]  ahead1_i,
  input  logic [rxc_pkg::BYTE_W-1:0]  ahead2_i,
  input  logic [rxc_pkg::BYTE_W-1:0]  ahead3_i,
  input  logic                        frame_end_i,
  output logic                        sum_en_o
);
  import rxc_pkg::*;

  localparam int unsigned MAX_SKIP = (MAC_ADDR_BYTES > SNAP_BYTES) ?
                                     MAC_ADDR_BYTES : SNAP_BYTES;
  localparam int unsigned CW = $clog2(MAX_SKIP);
  localparam int unsigned TW = $clog2(MAX_TAGS + 1);

  parse_st_e          st_q, st_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [TW-1:0]      tags_q, tags_d;
  logic [BYTE_W-1:0]  thi_q, thi_d;
  logic [WORD_W-1:0]  type_w;
  logic               is_tag, is_snap;

  assign type_w  = {thi_q, pop_byte_i};
  assign is_tag  = l3_mode_i && (type_w == tag_type_i) &&
                   (tags_q < TW'(MAX_TAGS));
  assign is_snap = l3_mode_i && (type_w < LEN_CEIL) &&
                   (ahead1_i == SNAP_SAP) && (ahead2_i == SNAP_SAP) &&
                   (ahead3_i == SNAP_UI);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    tags_d = tags_q;
    thi_d  = thi_q;
    if (pop_valid_i) begin
      unique case (st_q)
        PS_HDR: begin
          if (cnt_q == '0) st_d = PS_THI;
          else             cnt_d = cnt_q - 1'b1;
        end
        PS_THI: begin
          thi_d = pop_byte_i;
          st_d  = PS_TLO;
        end
        PS_TLO: begin
          if (is_tag) begin
            tags_d = tags_q + 1'b1;
            cnt_d  = CW'(TAG_BODY_BYTES - 1);
            st_d   = PS_HDR;
          end else if (is_snap) begin
            cnt_d = CW'(SNAP_BYTES - 1);
            st_d  = PS_SNAP;
          end else begin
            st_d = PS_SUM;
          end
        end
        PS_SNAP: begin
          if (cnt_q == '0) st_d = PS_SUM;
          else             cnt_d = cnt_q - 1'b1;
        end
        PS_SUM:  st_d = PS_SUM;
        default: st_d = PS_HDR;
      endcase
    end
    if (frame_end_i) begin
      st_d   = PS_HDR;
      cnt_d  = CW'(MAC_ADDR_BYTES - 1);
      tags_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_HDR;
      cnt_q  <= CW'(MAC_ADDR_BYTES - 1);
      tags_q <= '0;
      thi_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tags_q <= tags_d;
      thi_q  <= thi_d;
    end
  end

  assign sum_en_o = pop_valid_i && (st_q == PS_SUM);

endmodule

// File: rtl/rxc_ones_sum.sv
module rxc_ones_sum (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        byte_en_i,
  input  logic [rxc_pkg::BYTE_W-1:0]  byte_i,
  input  logic                        frame_end_i,
  output logic                        res_valid_o,
  output logic [rxc_pkg::WORD_W-1:0]  res_o
);
  import rxc_pkg::*;

  logic [WORD_W-1:0] acc_q, acc_d, acc_n;
  logic              half_q, half_d, half_n;
  logic [BYTE_W-1:0] hold_q, hold_d, hold_n;
  logic [WORD_W-1:0] res_q, res_d;
  logic              vld_q, vld_d;
  logic [WORD_W:0]   add1, add2;
  logic [WORD_W-1:0] pad, fin;

  // Pair bytes into big-endian words and fold each carry back in
  always_comb begin
    acc_n  = acc_q;
    half_n = half_q;
    hold_n = hold_q;
    add1   = '0;
    if (byte_en_i) begin
      if (half_q) begin
        add1   = {1'b0, acc_q} + {1'b0, hold_q, byte_i};
        acc_n  = add1[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, add1[WORD_W]};
        half_n = 1'b0;
      end else begin
        hold_n = byte_i;
        half_n = 1'b1;
      end
    end
  end

  // Close the frame: a dangling high byte is paired with a zero low byte
  always_comb begin
    pad  = half_n ? {hold_n, {BYTE_W{1'b0}}} : '0;
    add2 = {1'b0, acc_n} + {1'b0, pad};
    fin  = add2[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, add2[WORD_W]};
  end

  always_comb begin
    acc_d  = acc_n;
    half_d = half_n;
    hold_d = hold_n;
    res_d  = res_q;
    vld_d  = frame_end_i;
    if (frame_end_i) begin
      res_d  = fin;
      acc_d  = '0;
      half_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      half_q <= 1'b0;
      hold_q <= '0;
      res_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      half_q <= half_d;
      hold_q <= hold_d;
      res_q  <= res_d;
      vld_q  <= vld_d;
    end
  end

  assign res_valid_o = vld_q;
  assign res_o       = res_q;

endmodule

// File: rtl/rx_csum_engine.sv
module rx_csum_engine #(
  parameter int unsigned FCS_BYTES      = 4,
  parameter int unsigned MAC_ADDR_BYTES = 12,
  parameter int unsigned TAG_BODY_BYTES = 2,
  parameter int unsigned SNAP_BYTES     = 8,
  parameter int unsigned MAX_TAGS       = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_l3_mode,
  input  logic [15:0] cfg_tag_type,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        csum_valid,
  output logic [15:0] csum_out
);
  import rxc_pkg::*;

  localparam int unsigned FW = $clog2(FCS_BYTES + 1);

  logic [1:0]                         rst_sync_q;
  logic                               rst_core_n;
  logic                               frame_end;
  logic                               pop_valid;
  logic [BYTE_W-1:0]                  pop_byte;
  logic [FCS_BYTES-2:0][BYTE_W-1:0]   ahead;
  logic [FW-1:0]                      dl_fill;
  logic                               sum_en;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign frame_end = in_valid && in_last;

  rxc_fcs_delay #(
    .DEPTH(FCS_BYTES)
  ) u_delay (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .in_valid_i (in_valid),
    .in_data_i  (in_data),
    .in_last_i  (in_last),
    .pop_valid_o(pop_valid),
    .pop_byte_o (pop_byte),
    .ahead_o    (ahead),
    .fill_o     (dl_fill)
  );

  // Bytes still in the delay line at end of frame are the check sequence;
  // the three behind the head also serve as the LLC/SNAP lookahead.
  rxc_hdr_parser #(
    .MAC_ADDR_BYTES(MAC_ADDR_BYTES),
    .TAG_BODY_BYTES(TAG_BODY_BYTES),
    .SNAP_BYTES    (SNAP_BYTES),
    .MAX_TAGS      (MAX_TAGS)
  ) u_parser (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .l3_mode_i  (cfg_l3_mode),
    .tag_type_i (cfg_tag_type),
    .pop_valid_i(pop_valid),
    .pop_byte_i (pop_byte),
    .ahead1_i   (ahead[0]),
    .ahead2_i   (ahead[1]),
    .ahead3_i   (ahead[2]),
    .frame_end_i(frame_end),
    .sum_en_o   (sum_en)
  );

  rxc_ones_sum u_sum (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .byte_en_i  (sum_en),
    .byte_i     (pop_byte),
    .frame_end_i(frame_end),
    .res_valid_o(csum_valid),
    .res_o      (csum_out)
  );

endmodule

// File: rtl/rx_csum_engine_chk.sv
module rx_csum_engine_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned FW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_last,
  input logic          csum_valid,
  input logic [15:0]   csum_out,
  input logic          pop_valid,
  input logic          sum_en,
  input logic [FW-1:0] fill
);

  // R1: outputs cleared while the core is in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!csum_valid && csum_out == 16'h0000));

  // R2: a strobe follows every frame end
  a_r2_strobe_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> csum_valid);

  // R2: no strobe without a frame end
  a_r2_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !csum_valid);

  // R2: result held between frame ends
  a_r2_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> $stable(csum_out));

  // R3: only bytes leaving the full delay line may be summed
  a_r3_sum_only_popped: assert property (@(posedge clk) disable iff (!rst_n)
    sum_en |-> (pop_valid && in_valid));

  // R3: the delay line never holds more than the check sequence length
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  // R12: delay line emptied for the next frame
  a_r12_fill_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> (fill == '0));

endmodule

bind rx_csum_engine rx_csum_engine_chk #(
  .DEPTH(FCS_BYTES),
  .FW   ($clog2(FCS_BYTES + 1))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .csum_valid(csum_valid),
  .csum_out  (csum_out),
  .pop_valid (pop_valid),
  .sum_en    (sum_en),
  .fill      (dl_fill)
);

// File: tb/rx_csum_engine_bench.sv
`timescale 1ns/1ps
module rx_csum_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cfg_l3_mode = 1'b0;
  logic [15:0] cfg_tag_type = 16'h8100;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic        csum_valid;
  logic [15:0] csum_out;

  always #4 clk = ~clk;

  rx_csum_engine u_rx_csum_engine (
    .clk(clk), .rst_n(rst_n), .cfg_l3_mode(cfg_l3_mode),
    .cfg_tag_type(cfg_tag_type), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .csum_valid(csum_valid), .csum_out(csum_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0]  frm  [0:255];
  logic [7:0]  keep [0:255];
  logic [15:0] res_log [0:255];
  int          n_res = 0;
  logic        mon_on = 1'b0;
  logic        last_seen = 1'b0;
  logic        have_prev = 1'b0;
  logic [15:0] prev_out = 16'h0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R2 monitor: strobe timing and hold, sampled away from the clock edge
  always @(posedge clk) last_seen <= in_valid && in_last;
  always @(negedge clk) begin
    if (mon_on) begin
      n_cmp++;
      if (csum_valid !== last_seen) begin
        n_bad++;
        $display("FAIL R2 strobe: actual %b expected %b", csum_valid, last_seen);
      end
      if (csum_valid) begin
        res_log[n_res] = csum_out;
        n_res++;
      end else if (have_prev && csum_out !== prev_out) begin
        n_bad++;
        $display("FAIL R2 hold: actual %h expected %h", csum_out, prev_out);
      end
      prev_out  = csum_out;
      have_prev = 1'b1;
    end
  end

  // Independent model of the start offset and the sum
  function automatic logic [15:0] ref_sum(input int len, input logic mode,
                                          input logic [15:0] tag);
    int pos, tags, stop;
    logic [31:0] s;
    logic [15:0] t;
    bit done;
    if (!mode) pos = 14;
    else begin
      pos = 12; tags = 0; done = 0;
      while (!done) begin
        t = {frm[pos], frm[pos+1]};
        if (t == tag && tags < 2) begin tags++; pos += 4; end
        else if (t < 16'h0600 && frm[pos+2] == 8'hAA && frm[pos+3] == 8'hAA &&
                 frm[pos+4] == 8'h03) begin pos += 10; done = 1; end
        else begin pos += 2; done = 1; end
      end
    end
    stop = len - 4;
    s = 0;
    for (int i = pos; i < stop; i += 2)
      s += {frm[i], (i + 1 < stop) ? frm[i+1] : 8'h00};
    s = s[15:0] + s[31:16];
    s = s[15:0] + s[31:16];
    return s[15:0];
  endfunction

  task automatic build(input int len, input int seed);
    for (int i = 0; i < 256; i++) frm[i] = 8'(i * 29 + seed * 7 + 3);
    frm[12] = 8'h08; frm[13] = 8'h00;
    if (len < 256) frm[len] = 8'h00;
  endtask

  task automatic send(input int len, input int gap, input bit chain);
    for (int i = 0; i < len; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) begin
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0; in_data = 8'h5A;
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = frm[i]; in_last = (i == len - 1);
    end
    if (!chain) begin
      @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    end
  endtask

  task automatic run(input string req, input int len, input logic mode,
                     input logic [15:0] tag, input int gap);
    logic [15:0] exp;
    int base;
    @(negedge clk);
    cfg_l3_mode = mode; cfg_tag_type = tag;
    exp  = ref_sum(len, mode, tag);
    base = n_res;
    send(len, gap, 1'b0);
    repeat (2) @(negedge clk);
    chk(req, (n_res == base + 1) ? res_log[base] : 16'hDEAD, exp);
  endtask

  task automatic t_reset;
    chk("R1 valid", {15'h0, csum_valid}, 16'h0);
    chk("R1 value", csum_out, 16'h0);
  endtask

  task automatic t_mode0;
    build(64, 1); run("R4 type II", 64, 1'b0, 16'h8100, 0);
    build(64, 2); frm[12] = 8'h81; frm[13] = 8'h00;
    run("R4 tag ignored", 64, 1'b0, 16'h8100, 0);
    build(16, 3); run("R3 short frame zero", 16, 1'b0, 16'h8100, 0);
    build(60, 4); frm[56] = 8'hFF; frm[57] = 8'h00; frm[58] = 8'h12; frm[59] = 8'h34;
    run("R3 check sequence A", 60, 1'b0, 16'h8100, 0);
    frm[56] = 8'h00; frm[57] = 8'hEE; frm[58] = 8'h77; frm[59] = 8'h01;
    run("R3 check sequence B", 60, 1'b0, 16'h8100, 0);
  endtask

  task automatic t_tags;
    build(70, 5); run("R5 type II", 70, 1'b1, 16'h8100, 0);
    build(70, 6); frm[12] = 8'h81; frm[13] = 8'h00; frm[16] = 8'h08; frm[17] = 8'h00;
    run("R6 one tag", 70, 1'b1, 16'h8100, 0);
    build(70, 7); frm[12] = 8'h81; frm[13] = 8'h00; frm[16] = 8'h81; frm[17] = 8'h00;
    frm[20] = 8'h08; frm[21] = 8'h00;
    run("R7 two tags", 70, 1'b1, 16'h8100, 0);
    frm[20] = 8'h81; frm[21] = 8'h00;
    run("R7 third tag summed", 70, 1'b1, 16'h8100, 0);
    build(70, 8); frm[12] = 8'h88; frm[13] = 8'hA8; frm[16] = 8'h08; frm[17] = 8'h00;
    run("R8 custom tag skipped", 70, 1'b1, 16'h88A8, 0);
    build(70, 9); frm[12] = 8'h81; frm[13] = 8'h00;
    run("R8 default value not a tag", 70, 1'b1, 16'h88A8, 0);
  endtask

  task automatic t_llc;
    build(72, 10); frm[12] = 8'h00; frm[13] = 8'h40;
    frm[14] = 8'hAA; frm[15] = 8'hAA; frm[16] = 8'h03;
    frm[17] = 8'h00; frm[18] = 8'h00; frm[19] = 8'h00; frm[20] = 8'h08; frm[21] = 8'h00;
    run("R9 snap", 72, 1'b1, 16'h8100, 0);
    build(72, 11); frm[12] = 8'h81; frm[13] = 8'h00; frm[16] = 8'h00; frm[17] = 8'h30;
    frm[18] = 8'hAA; frm[19] = 8'hAA; frm[20] = 8'h03;
    run("R9 snap after tag", 72, 1'b1, 16'h8100, 0);
    build(72, 12); frm[12] = 8'h00; frm[13] = 8'h40;
    frm[14] = 8'h42; frm[15] = 8'h42; frm[16] = 8'h03;
    run("R10 plain length", 72, 1'b1, 16'h8100, 0);
  endtask

  task automatic t_arith;
    build(65, 13); run("R11 odd length", 65, 1'b0, 16'h8100, 0);
    build(80, 14);
    for (int i = 14; i < 80; i++) frm[i] = 8'hC0 | 8'(i);
    run("R11 carries", 80, 1'b1, 16'h8100, 0);
    build(19, 15); frm[14] = 8'hAB;
    run("R11 single padded byte", 19, 1'b0, 16'h8100, 0);
  endtask

  task automatic t_stream;
    logic [15:0] ea, eb;
    int base;
    build(64, 16); run("R12 idle gaps", 64, 1'b1, 16'h8100, 3);
    @(negedge clk);
    cfg_l3_mode = 1'b1; cfg_tag_type = 16'h8100;
    build(41, 17); frm[12] = 8'h81; frm[13] = 8'h00; frm[16] = 8'h08; frm[17] = 8'h00;
    ea = ref_sum(41, 1'b1, 16'h8100);
    for (int i = 0; i < 256; i++) keep[i] = frm[i];
    build(50, 18); eb = ref_sum(50, 1'b1, 16'h8100);
    for (int i = 0; i < 256; i++) begin logic [7:0] x; x = frm[i]; frm[i] = keep[i]; keep[i] = x; end
    base = n_res;
    send(41, 0, 1'b1);
    for (int i = 0; i < 256; i++) frm[i] = keep[i];
    send(50, 0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R12 back to back first", (n_res >= base + 1) ? res_log[base] : 16'hDEAD, ea);
    chk("R12 back to back second", (n_res >= base + 2) ? res_log[base+1] : 16'hDEAD, eb);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    mon_on = 1'b1;
    t_mode0();
    t_tags();
    t_llc();
    t_arith();
    t_stream();
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule